// File: doc/BRIEF.md
# Framed Serial Character Transmitter

This block sends characters on a single serial output line. Software drives a small register port. It sets up the character format and the enables, reads the status word, and writes one character into a holding buffer. A scheduler moves the buffered character into an 11-bit shift register, wrapped with a low start bit and a high stop bit. The shift register then clocks the character out least significant bit first. One bit lasts sixteen pulses of the external `baud_tick` enable.

When the transmitter becomes enabled, it first sends one frame of idle 1s before any data. A break control holds the line low for whole frames. When break is released, the block sends at least one bit time of 1 before the next frame. Two flags are available: buffer-empty and transmission-complete. Each flag has an enable that gates its request output. The register port has no back-pressure: every access completes in the cycle it is presented, and a write to the data address is always taken.

Register map (byte wide, `bus_addr`): 0 = control {bit0 global enable, bit1 transmit enable, bit2 break, bit3 empty request enable, bit4 complete request enable}. 1 = format {bit0 nine-bit mode, bit1 ninth data bit, bit2 parity enable, bit3 odd parity}. 2 = status, read only {bit0 empty, bit1 complete}. 3 = data, write only, reads 0.

Top module: `sertx_core`

## Requirements
- R1: After reset `txd` is 1, both request outputs are 0, control and format read 0, and status reads 0x03 (empty and complete set).
- R2: No character leaves the block unless both the global enable (control bit 0) and the transmit enable (control bit 1) are 1. While either is 0, `txd` stays 1 and a buffered character stays pending.
- R3: When both enables become 1, one frame of all 1s is sent first. A buffered character starts one frame time (frame length × 16 ticks) after the enabling write, give or take three cycles.
- R4: A data frame is a 0 start bit, then the data bits least significant first, then a 1 stop bit. Each bit lasts exactly 16 `baud_tick` pulses, however the ticks are spaced.
- R5: With format bit 0 set, frames carry nine data bits and the ninth is format bit 1. Otherwise frames carry eight.
- R6: With parity enabled (format bit 2), the last data-bit position carries parity over the data bits below it. The parity is even when format bit 3 is 0 and odd when it is 1.
- R7: A data write clears the empty flag only if a status read saw the flag set since the previous data write. A write without that read leaves the flag set and sends nothing.
- R8: The empty flag sets in the cycle the buffer moves into the shift register. A character written while another is shifting follows it with no idle gap.
- R9: The complete flag is 1 only when the shifter is idle with nothing pending. An accepted data write clears it.
- R10: `irq_empty` equals empty AND control bit 3, and `irq_done` equals complete AND control bit 4.
- R11: While break (control bit 2) is set with both enables, `txd` is low for whole frames. After release, exactly one bit time of 1 precedes the next frame.
- R12: Clearing the transmit enable mid-character lets that character finish intact. After that `txd` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe (status read arms the data write) |
| bus_addr | input | 2 | register address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for `bus_addr` |
| baud_tick | input | 1 | baud enable, 16 per bit time |
| txd | output | 1 | serial output, idle high |
| irq_empty | output | 1 | gated buffer-empty request |
| irq_done | output | 1 | gated transmission-complete request |

## Verification
The bench sweeps all eight combinations of nine-bit mode, parity enable and parity sense against eight data patterns. It decodes every frame from `txd` and compares it with a frame computed arithmetically; a wrong parity sense or a misplaced ninth bit shows up as a single wrong bit. It times the enable-to-first-start-bit interval, so a design that skipped the preamble would start about 160 cycles early. It also measures the break low run and the high gap after release, which catches a one-cycle idle glitch between break frames or a missing stop-level bit. A data write with no prior status read must leave `txd` idle; a design that ignored the arming rule would send a stray character. The bench also drops the transmit enable mid-character and checks that the character is not truncated. It spaces the ticks three cycles apart to check that bit time counts ticks, not clocks.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int CHAR_W    = 8;
  localparam int FRAME_MAX = CHAR_W + 3;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FMT  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  typedef enum logic [1:0] {
    FK_DATA = 2'd0,
    FK_PRE  = 2'd1,
    FK_BRK  = 2'd2,
    FK_TAIL = 2'd3
  } frame_kind_e;

  typedef struct packed {
    logic ie_done;
    logic ie_empty;
    logic brk;
    logic tx_en;
    logic glob_en;
  } ctrl_t;

  typedef struct packed {
    logic par_odd;
    logic par_en;
    logic ninth;
    logic nine;
  } fmt_t;
endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              take_data,
  input  logic              done_flag,
  output logic [7:0]        bus_rdata,
  output ctrl_t             ctl,
  output fmt_t              fmt,
  output logic [CHAR_W-1:0] buf_data,
  output logic              empty
);
  logic [7:0] ctrl_raw;
  logic [7:0] fmt_raw;
  logic       armed;
  logic       wr_data;
  logic       rd_stat;

  assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
  assign rd_stat = bus_rd && (bus_addr == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_raw <= '0;
      fmt_raw  <= '0;
      buf_data <= '0;
      empty    <= 1'b1;
      armed    <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADDR_CTRL) ctrl_raw <= {3'b000, bus_wdata[4:0]};
      if (bus_wr && bus_addr == ADDR_FMT)  fmt_raw  <= {4'b0000, bus_wdata[3:0]};
      if (wr_data) buf_data <= bus_wdata[CHAR_W-1:0];
      if (take_data)                      empty <= 1'b1;
      else if (wr_data && armed && empty) empty <= 1'b0;
      if (wr_data)                armed <= 1'b0;
      else if (rd_stat && empty)  armed <= 1'b1;
    end
  end

  assign ctl = '{ie_done: ctrl_raw[4], ie_empty: ctrl_raw[3], brk: ctrl_raw[2],
                 tx_en: ctrl_raw[1], glob_en: ctrl_raw[0]};
  assign fmt = '{par_odd: fmt_raw[3], par_en: fmt_raw[2], ninth: fmt_raw[1], nine: fmt_raw[0]};

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_raw;
      ADDR_FMT:  bus_rdata = fmt_raw;
      ADDR_STAT: bus_rdata = {6'b000000, done_flag, empty};
      default:   bus_rdata = 8'h00;
    endcase
  end

  // R7: the flag may only drop on a write that was preceded by an arming read
  assert_empty_clear_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty) |-> $past(armed) && $past(wr_data));

  // R8: the flag returns only when the shifter took the buffer
  assert_empty_sets_on_transfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> $past(take_data));
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
(
  input  frame_kind_e          kind,
  input  fmt_t                 fmt,
  input  logic [CHAR_W-1:0]    data,
  output logic [FRAME_MAX-1:0] frame,
  output logic [LEN_W-1:0]     len
);
  localparam int WORD_W = CHAR_W + 1;

  logic [WORD_W-1:0]    word;
  logic [LEN_W-1:0]     nbits;
  logic                 par;
  logic [FRAME_MAX-1:0] data_frame;

  always_comb begin
    nbits = fmt.nine ? LEN_W'(CHAR_W + 1) : LEN_W'(CHAR_W);
    word  = {fmt.ninth, data};
    par   = fmt.par_odd;
    for (int i = 0; i < WORD_W - 1; i++) begin
      if (LEN_W'(i) < nbits - LEN_W'(1)) par = par ^ word[i];
    end
    data_frame    = '1;
    data_frame[0] = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (LEN_W'(i) < nbits) begin
        data_frame[i+1] = (fmt.par_en && LEN_W'(i) == nbits - LEN_W'(1)) ? par : word[i];
      end
    end
    unique case (kind)
      FK_DATA: begin frame = data_frame; len = nbits + LEN_W'(2); end
      FK_PRE:  begin frame = '1;         len = nbits + LEN_W'(2); end
      FK_BRK:  begin frame = '0;         len = nbits + LEN_W'(2); end
      default: begin frame = '1;         len = LEN_W'(1);         end
    endcase
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int OVS_TICKS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] frame,
  input  logic [LEN_W-1:0]     len,
  output logic                 busy,
  output logic                 ready,
  output logic                 txd
);
  localparam int SUB_W = (OVS_TICKS > 1) ? $clog2(OVS_TICKS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS_TICKS - 1);

  logic [FRAME_MAX-1:0] shreg;
  logic [LEN_W-1:0]     left;
  logic [SUB_W-1:0]     sub;
  logic                 bit_end;

  assign bit_end = busy && tick && (sub == SUB_LAST);
  assign ready   = !busy || (bit_end && left == LEN_W'(1));
  assign txd     = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
      sub   <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= frame;
      left  <= len;
      sub   <= '0;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (sub == SUB_LAST) begin
        sub   <= '0;
        shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
        left  <= left - LEN_W'(1);
        if (left == LEN_W'(1)) busy <= 1'b0;
      end else begin
        sub <= sub + SUB_W'(1);
      end
    end
  end

  // R4: a bit level only changes on a baud tick
  assert_bit_holds_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(txd));

  // R4: an active frame always has bits left to send
  assert_frame_has_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> left != '0);
endmodule

// File: rtl/sertx_sched.sv
module sertx_sched
  import sertx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        brk,
  input  logic        buf_full,
  input  logic        ready,
  output logic        load,
  output frame_kind_e kind,
  output logic        pre_pend,
  output logic        brk_tail
);
  logic en_q;
  logic want_pre;

  assign want_pre = en && (pre_pend || !en_q);

  always_comb begin
    load = 1'b0;
    kind = FK_DATA;
    if (ready) begin
      if (en && brk)         begin load = 1'b1; kind = FK_BRK;  end
      else if (brk_tail)     begin load = 1'b1; kind = FK_TAIL; end
      else if (want_pre)     begin load = 1'b1; kind = FK_PRE;  end
      else if (en && buf_full) begin load = 1'b1; kind = FK_DATA; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pre_pend <= 1'b0;
      brk_tail <= 1'b0;
    end else begin
      en_q     <= en;
      pre_pend <= want_pre && !(load && kind == FK_PRE);
      if (load && kind == FK_BRK)       brk_tail <= 1'b1;
      else if (load && kind == FK_TAIL) brk_tail <= 1'b0;
    end
  end

  // R11: the released-break tail is only ever sent after a break frame
  assert_tail_after_break_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_tail) |-> $past(load) && $past(kind) == FK_BRK);
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int OVS_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       baud_tick,
  output logic       txd,
  output logic       irq_empty,
  output logic       irq_done
);
  ctrl_t                ctl;
  fmt_t                 fmt;
  logic [CHAR_W-1:0]    buf_data;
  logic                 empty;
  logic                 done_flag;
  logic                 en;
  logic                 load;
  frame_kind_e          kind;
  logic                 pre_pend;
  logic                 brk_tail;
  logic                 take_data;
  logic [FRAME_MAX-1:0] frame;
  logic [LEN_W-1:0]     len;
  logic                 sh_busy;
  logic                 sh_ready;

  assign en        = ctl.glob_en && ctl.tx_en;
  assign take_data = load && (kind == FK_DATA);
  assign done_flag = empty && !sh_busy && !pre_pend && !brk_tail;
  assign irq_empty = empty && ctl.ie_empty;
  assign irq_done  = done_flag && ctl.ie_done;

  sertx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .take_data(take_data),
    .done_flag(done_flag), .bus_rdata(bus_rdata), .ctl(ctl), .fmt(fmt),
    .buf_data(buf_data), .empty(empty)
  );

  sertx_sched u_sched (
    .clk(clk), .rst_n(rst_n), .en(en), .brk(ctl.brk), .buf_full(!empty),
    .ready(sh_ready), .load(load), .kind(kind), .pre_pend(pre_pend),
    .brk_tail(brk_tail)
  );

  sertx_framer u_framer (
    .kind(kind), .fmt(fmt), .data(buf_data), .frame(frame), .len(len)
  );

  sertx_shifter #(.OVS_TICKS(OVS_TICKS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(load), .frame(frame),
    .len(len), .busy(sh_busy), .ready(sh_ready), .txd(txd)
  );

  // R2: a buffered character is only taken while both enables are set
  assert_take_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_data |-> ctl.glob_en && ctl.tx_en);

  // R4: the cycle after a character is taken the line shows its start bit
  assert_start_bit_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_data |=> !txd);
endmodule

// File: tb/sim_sertx_core.sv
module sim_sertx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       baud_tick = 1'b0;
  logic       txd;
  logic       irq_empty;
  logic       irq_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_div = 1;
  int tcnt = 0;
  bit finished = 1'b0;

  sertx_core u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_tick(baud_tick), .txd(txd), .irq_empty(irq_empty), .irq_done(irq_done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    tcnt <= tcnt + 1;
    baud_tick <= ((tcnt % tick_div) == 0);
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_ctrl(input bit g, input bit t, input bit b, input bit ie, input bit id);
    wr(2'd0, {3'b000, id, ie, b, t, g});
  endtask

  task automatic set_fmt(input bit nine, input bit ninth, input bit pe, input bit po);
    wr(2'd1, {4'b0000, po, pe, ninth, nine});
  endtask

  task automatic send(input logic [7:0] d);
    logic [7:0] s;
    int guard = 0;
    do begin rd(2'd2, s); guard++; end while (s[0] !== 1'b1 && guard < 5000);
    wr(2'd3, d);
  endtask

  task automatic recv(input int len, input bit started, output logic [10:0] bits, output int tf);
    int guard = 0;
    if (!started) begin
      do begin @(negedge clk); guard++; end while (txd !== 1'b0 && guard < 20000);
    end
    tf = cyc;
    bits = '1;
    repeat (8 * tick_div) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < len; i++) begin
      repeat (16 * tick_div) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  task automatic stays_idle(input int n, input string req);
    int lows = 0;
    repeat (n) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    check(lows == 0, req, lows, 0);
  endtask

  function automatic logic [10:0] expect_frame(logic [7:0] d, bit ninth, bit nine, bit pe, bit po);
    int nb = nine ? 9 : 8;
    logic [8:0] v = {ninth, d};
    logic p = po;
    logic [10:0] f = '1;
    for (int i = 0; i < nb - 1; i++) p = p ^ v[i];
    if (pe) v[nb-1] = p;
    f[0] = 1'b0;
    for (int i = 0; i < nb; i++) f[i+1] = v[i];
    return f;
  endfunction

  initial begin
    logic [7:0] s;
    logic [10:0] got;
    logic [10:0] got2;
    int tf, tf2, t_en, t0, t1, t2, n;
    logic [7:0] pats [8];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
    pats[4] = 8'h01; pats[5] = 8'h80; pats[6] = 8'h7E; pats[7] = 8'hC3;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(txd === 1'b1, "R1 txd idle", txd, 1);
    check(irq_empty === 1'b0 && irq_done === 1'b0, "R1 requests low", {irq_empty, irq_done}, 0);
    rd(2'd0, s); check(s == 8'h00, "R1 control", s, 0);
    rd(2'd1, s); check(s == 8'h00, "R1 format", s, 0);
    rd(2'd2, s); check(s == 8'h03, "R1 status", s, 3);

    // R10 gating of requests
    check(irq_empty === 1'b0 && irq_done === 1'b0, "R10 gated off", {irq_empty, irq_done}, 0);
    set_ctrl(0, 0, 0, 1, 1);
    @(negedge clk);
    check(irq_empty === 1'b1 && irq_done === 1'b1, "R10 gated on", {irq_empty, irq_done}, 3);

    // R2 one enable alone sends nothing
    set_ctrl(1, 0, 0, 1, 1);
    send(8'h3C);
    @(negedge clk);
    check(irq_empty === 1'b0, "R2 character pending", irq_empty, 0);
    stays_idle(300, "R2 global only");
    set_ctrl(0, 1, 0, 1, 1);
    stays_idle(300, "R2 transmit only");
    check(irq_empty === 1'b0, "R2 still pending", irq_empty, 0);

    // R3 preamble before the pending character
    set_ctrl(1, 1, 0, 1, 1);
    t_en = cyc;
    recv(10, 0, got, tf);
    check(tf - t_en >= 160 && tf - t_en <= 163, "R3 preamble delay", tf - t_en, 161);
    check(got == expect_frame(8'h3C, 0, 0, 0, 0), "R3 data after preamble", got, expect_frame(8'h3C, 0, 0, 0, 0));

    // R4 R5 R6 sweep of formats and patterns
    for (int c = 0; c < 8; c++) begin
      for (int j = 0; j < 8; j++) begin
        bit nine = c[0];
        bit pe = c[1];
        bit po = c[2];
        logic [10:0] ex;
        set_fmt(nine, j[0], pe, po);
        send(pats[j]);
        recv(nine ? 11 : 10, 0, got, tf);
        ex = expect_frame(pats[j], j[0], nine, pe, po);
        if (pe)        check(got == ex, "R6 parity frame", got, ex);
        else if (nine) check(got == ex, "R5 nine-bit frame", got, ex);
        else           check(got == ex, "R4 eight-bit frame", got, ex);
      end
    end

    // R4 bit time counts ticks, not clocks
    set_fmt(0, 0, 0, 0);
    tick_div = 3;
    send(8'h01);
    do @(negedge clk); while (txd !== 1'b0);
    n = 0;
    while (txd === 1'b0 && n < 1000) begin n++; @(negedge clk); end
    check(n >= 47 && n <= 49, "R4 start bit 16 ticks", n, 48);
    repeat (16 * 3 * 10) @(negedge clk);
    send(8'h96);
    recv(10, 0, got, tf);
    check(got == expect_frame(8'h96, 0, 0, 0, 0), "R4 slow ticks frame", got, expect_frame(8'h96, 0, 0, 0, 0));
    tick_div = 1;
    repeat (200) @(negedge clk);

    // R7 write without arming read is ignored
    wr(2'd3, 8'h11);
    @(negedge clk);
    check(irq_empty === 1'b1, "R7 flag stays set", irq_empty, 1);
    stays_idle(300, "R7 no stray frame");
    send(8'h5A);
    recv(10, 0, got, tf);
    check(got == expect_frame(8'h5A, 0, 0, 0, 0), "R7 armed write sent", got, expect_frame(8'h5A, 0, 0, 0, 0));
    repeat (200) @(negedge clk);

    // R8 R9 double buffering and completion
    send(8'hC3);
    check(irq_empty === 1'b0 && irq_done === 1'b0, "R9 write clears flags", {irq_empty, irq_done}, 0);
    fork
      begin
        recv(10, 0, got, tf);
        recv(10, 0, got2, tf2);
      end
      begin
        @(negedge clk);
        check(irq_empty === 1'b1, "R8 empty on transfer", irq_empty, 1);
        check(irq_done === 1'b0, "R9 busy not complete", irq_done, 0);
        send(8'h3C);
      end
    join
    check(got == expect_frame(8'hC3, 0, 0, 0, 0), "R8 first frame", got, expect_frame(8'hC3, 0, 0, 0, 0));
    check(got2 == expect_frame(8'h3C, 0, 0, 0, 0), "R8 second frame", got2, expect_frame(8'h3C, 0, 0, 0, 0));
    check(tf2 - tf == 160, "R8 no gap", tf2 - tf, 160);
    check(irq_done === 1'b0, "R9 complete low in stop bit", irq_done, 0);
    repeat (20) @(negedge clk);
    check(irq_done === 1'b1, "R9 complete after idle", irq_done, 1);
    rd(2'd2, s); check(s == 8'h03, "R9 status idle", s, 3);

    // R11 break frames and stop tail
    set_ctrl(1, 1, 1, 1, 1);
    do @(negedge clk); while (txd !== 1'b0);
    t0 = cyc;
    repeat (400) @(negedge clk);
    set_ctrl(1, 1, 0, 1, 1);
    send(8'hA5);
    while (txd !== 1'b1) @(negedge clk);
    t1 = cyc;
    while (txd !== 1'b0) @(negedge clk);
    t2 = cyc;
    check((t1 - t0) % 160 == 0 && (t1 - t0) >= 160, "R11 whole break frames", t1 - t0, 480);
    check(t2 - t1 >= 15 && t2 - t1 <= 17, "R11 one stop bit after break", t2 - t1, 16);
    recv(10, 1, got, tf);
    check(got == expect_frame(8'hA5, 0, 0, 0, 0), "R11 data after break", got, expect_frame(8'hA5, 0, 0, 0, 0));
    repeat (200) @(negedge clk);

    // R12 disable mid character
    send(8'h0F);
    send(8'h77);
    fork
      recv(10, 0, got, tf);
      begin
        repeat (60) @(negedge clk);
        set_ctrl(1, 0, 0, 1, 1);
      end
    join
    check(got == expect_frame(8'h0F, 0, 0, 0, 0), "R12 character completes", got, expect_frame(8'h0F, 0, 0, 0, 0));
    stays_idle(400, "R12 idle after disable");
    check(irq_empty === 1'b0, "R12 next still pending", irq_empty, 0);
    set_ctrl(1, 1, 0, 1, 1);
    t_en = cyc;
    recv(10, 0, got, tf);
    check(tf - t_en >= 160 && tf - t_en <= 163, "R3 preamble on re-enable", tf - t_en, 161);
    check(got == expect_frame(8'h77, 0, 0, 0, 0), "R12 pending sent later", got, expect_frame(8'h77, 0, 0, 0, 0));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule